// File: doc/BRIEF.md
# Banked SRAM and Peripheral Mapper

This block maps an 8-bit CPU's 16-bit address space onto external SRAM and onto the register port of a byte-wide SCSI protocol controller. The range 0x4000 to 0xBFFF is split into four 8 KB windows. Each window has its own bank byte that decides what the window shows: a page of SRAM, either writable or read-only, or the controller.

Software changes a bank byte by writing anywhere in 0x6000 to 0x7FFF. Such writes never reach memory or the controller. Reads in that range still return the contents of the window mapped there.

When a window shows the controller, its lower 4 KB is a mirrored data-register port and its upper 4 KB reaches a 16-entry register file. Each CPU access to the controller produces one single-cycle strobe, however long the CPU holds its read or write line. The controller is outside this block.

Top module: `banked_sram_mapper`

## Requirements
- R1: The window index is (address / 0x2000) − 2 for addresses 0x4000–0xBFFF. For SRAM banks, `sram_addr` = {bank & (SRAM_KB/8 − 1), address[12:0]}, and `cpu_dout` returns `sram_rdata`.
- R2: A write in 0x6000–0x7FFF loads `cpu_din` into the bank byte selected by address bits 12:11. It raises neither `sram_we` nor any controller strobe.
- R3: A bank byte with bit 7 set makes its window writable, and a CPU write then drives `sram_we` with `sram_wdata` = `cpu_din`. With bit 7 clear, a write leaves `sram_we` low.
- R4: A bank byte whose bits 7:6 are 01 routes the window to the controller. Reads return `ctl_rdata` and `sram_we` stays low. Bits 7:6 of 11 select SRAM.
- R5: In a controller window, offsets below 0x1000 pulse `ctl_dreg_rd` on a read and `ctl_dreg_wr` on a write, with `ctl_wdata` = `cpu_din`.
- R6: In a controller window, offsets 0x1000 and above pulse `ctl_reg_rd` or `ctl_reg_wr`, with `ctl_reg_sel` = address[3:0].
- R7: Each CPU access raises exactly one controller strobe for one clock cycle, on the first cycle of the strobe. At most one strobe is active at a time.
- R8: Reads below 0x4000 or at 0xC000 and above return 0xFF. Accesses there cause no SRAM write and no controller strobe.
- R9: Reads in 0x6000–0x7FFF return the data of window 1.
- R10: While `rst_n` is low, all bank bytes become 0x00 (SRAM page 0, read-only), and `ctl_reset` is high.
- R11: `dbg_bank` shows bank byte n at bits 8n+7:8n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cpu_addr | input | 16 | CPU address |
| cpu_din | input | 8 | CPU write data |
| cpu_rd | input | 1 | CPU read strobe |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_dout | output | 8 | CPU read data |
| sram_addr | output | SRAM_KB/8 page bits + 13 | SRAM byte address |
| sram_we | output | 1 | SRAM write enable |
| sram_wdata | output | 8 | SRAM write data |
| sram_rdata | input | 8 | SRAM read data |
| ctl_reset | output | 1 | Controller reset |
| ctl_dreg_rd | output | 1 | Data-register read pulse |
| ctl_dreg_wr | output | 1 | Data-register write pulse |
| ctl_reg_rd | output | 1 | Register-file read pulse |
| ctl_reg_wr | output | 1 | Register-file write pulse |
| ctl_reg_sel | output | 4 | Register-file index |
| ctl_wdata | output | 8 | Controller write data |
| ctl_rdata | input | 8 | Controller read data |
| dbg_bank | output | 32 | All four bank bytes |

## Verification
The bench builds the block with SRAM_KB = 128, which gives a 4-bit page mask. A bank byte such as 0x9F or 0x25 therefore lands on a reduced page, and the truncation of the page field is checked directly. The bench holds every CPU strobe for two cycles, so a repeated controller pulse shows up as an extra count. It also covers the 0x40 and 0xC0 aliases in bits 7:6, so that only the 01 pattern selects the controller.

// File: rtl/banked_sram_mapper.sv
module banked_sram_mapper #(
  parameter int SRAM_KB = 1024,
  localparam int PAGES  = SRAM_KB / 8,
  localparam int PAGE_W = $clog2(PAGES),
  localparam int SA_W   = PAGE_W + 13
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [15:0]     cpu_addr,
  input  logic [7:0]      cpu_din,
  input  logic            cpu_rd,
  input  logic            cpu_wr,
  output logic [7:0]      cpu_dout,
  output logic [SA_W-1:0] sram_addr,
  output logic            sram_we,
  output logic [7:0]      sram_wdata,
  input  logic [7:0]      sram_rdata,
  output logic            ctl_reset,
  output logic            ctl_dreg_rd,
  output logic            ctl_dreg_wr,
  output logic            ctl_reg_rd,
  output logic            ctl_reg_wr,
  output logic [3:0]      ctl_reg_sel,
  output logic [7:0]      ctl_wdata,
  input  logic [7:0]      ctl_rdata,
  output logic [31:0]     dbg_bank
);

  logic [7:0] bank [4];
  logic       rd_q, wr_q;

  logic [2:0] win_raw;
  logic [1:0] win;
  logic [7:0] cur;
  logic       in_win, in_cfg, is_ctl, ctl_hit, dreg_area, rd_edge, wr_edge;

  assign win_raw   = cpu_addr[15:13] - 3'd2;
  assign win       = win_raw[1:0];
  assign in_win    = (cpu_addr[15:14] == 2'b01) || (cpu_addr[15:14] == 2'b10);
  assign in_cfg    = (cpu_addr[15:13] == 3'b011);
  assign cur       = bank[win];
  assign is_ctl    = (cur[7:6] == 2'b01);
  assign ctl_hit   = in_win && is_ctl;
  assign dreg_area = !cpu_addr[12];
  assign rd_edge   = cpu_rd && !rd_q;
  assign wr_edge   = cpu_wr && !wr_q && !in_cfg;

  assign sram_addr  = {cur[PAGE_W-1:0], cpu_addr[12:0]};
  assign sram_we    = cpu_wr && in_win && !in_cfg && !is_ctl && cur[7];
  assign sram_wdata = cpu_din;

  assign ctl_reset   = !rst_n;
  assign ctl_dreg_rd = rd_edge && ctl_hit && dreg_area;
  assign ctl_reg_rd  = rd_edge && ctl_hit && !dreg_area;
  assign ctl_dreg_wr = wr_edge && ctl_hit && dreg_area;
  assign ctl_reg_wr  = wr_edge && ctl_hit && !dreg_area;
  assign ctl_reg_sel = cpu_addr[3:0];
  assign ctl_wdata   = cpu_din;

  assign cpu_dout = !in_win ? 8'hFF : (is_ctl ? ctl_rdata : sram_rdata);
  assign dbg_bank = {bank[3], bank[2], bank[1], bank[0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q <= 1'b0;
      wr_q <= 1'b0;
      for (int i = 0; i < 4; i++) bank[i] <= 8'h00;
    end else begin
      rd_q <= cpu_rd;
      wr_q <= cpu_wr;
      if (cpu_wr && !wr_q && in_cfg) bank[cpu_addr[12:11]] <= cpu_din;
    end
  end

endmodule

module banked_sram_mapper_checks (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] cpu_addr,
  input logic [7:0]  cpu_din,
  input logic        cpu_rd,
  input logic        cpu_wr,
  input logic [7:0]  cpu_dout,
  input logic        sram_we,
  input logic        ctl_reset,
  input logic        ctl_dreg_rd,
  input logic        ctl_dreg_wr,
  input logic        ctl_reg_rd,
  input logic        ctl_reg_wr,
  input logic [31:0] dbg_bank
);
  logic       outside;
  logic [3:0] strobes;
  logic [1:0] idx_q;
  logic [7:0] din_q;
  logic       cfg_w_q;

  assign outside = (cpu_addr < 16'h4000) || (cpu_addr >= 16'hC000);
  assign strobes = {ctl_dreg_rd, ctl_dreg_wr, ctl_reg_rd, ctl_reg_wr};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= 2'd0; din_q <= 8'd0; cfg_w_q <= 1'b0;
    end else begin
      idx_q   <= cpu_addr[12:11];
      din_q   <= cpu_din;
      cfg_w_q <= $rose(cpu_wr) && (cpu_addr[15:13] == 3'b011);
    end
  end

  assert_strobe_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(strobes));
  assert_strobe_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (strobes != 4'b0) |=> (strobes == 4'b0));
  assert_cfg_no_side_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_addr[15:13] == 3'b011) |-> (!sram_we && strobes == 4'b0));
  assert_bank_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_w_q |-> (dbg_bank[8*idx_q +: 8] == din_q));
  assert_outside_ff_R8: assert property (@(posedge clk) disable iff (!rst_n)
    outside |-> (cpu_dout == 8'hFF && !sram_we && strobes == 4'b0));
  assert_reset_ctl_R10: assert property (@(posedge clk)
    !rst_n |-> ctl_reset);
  assert_no_we_without_wr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sram_we |-> cpu_wr);
  logic unused_rd;
  assign unused_rd = cpu_rd;
endmodule

bind banked_sram_mapper banked_sram_mapper_checks u_checks (
  .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_din(cpu_din),
  .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_dout(cpu_dout), .sram_we(sram_we),
  .ctl_reset(ctl_reset), .ctl_dreg_rd(ctl_dreg_rd), .ctl_dreg_wr(ctl_dreg_wr),
  .ctl_reg_rd(ctl_reg_rd), .ctl_reg_wr(ctl_reg_wr), .dbg_bank(dbg_bank)
);

// File: tb/banked_sram_mapper_test.sv
module banked_sram_mapper_test;
  localparam int CLK_P = 10;
  localparam int KB = 128;
  localparam int SA_W = $clog2(KB / 8) + 13;

  logic clk = 0, rst_n = 0;
  logic [15:0] cpu_addr = 0;
  logic [7:0] cpu_din = 0, ctl_rdata = 8'h3C;
  logic cpu_rd = 0, cpu_wr = 0;
  logic [7:0] cpu_dout, sram_wdata, ctl_wdata, sram_rdata;
  logic [SA_W-1:0] sram_addr;
  logic sram_we, ctl_reset, ctl_dreg_rd, ctl_dreg_wr, ctl_reg_rd, ctl_reg_wr;
  logic [3:0] ctl_reg_sel;
  logic [31:0] dbg_bank;

  int errors = 0, checks = 0;
  int n_drd = 0, n_dwr = 0, n_rrd = 0, n_rwr = 0;
  logic [7:0] cap_dout, cap_wd, cap_cwd;
  logic [SA_W-1:0] cap_sa;
  logic cap_we;
  logic [3:0] cap_sel;

  always #(CLK_P/2) clk = ~clk;

  function automatic logic [7:0] patt(input logic [SA_W-1:0] a);
    return a[7:0] ^ a[15:8] ^ {7'd0, a[16]};
  endfunction
  assign sram_rdata = patt(sram_addr);

  banked_sram_mapper #(.SRAM_KB(KB)) uut (.*);

  always @(posedge clk) begin
    if (ctl_dreg_rd) n_drd++;
    if (ctl_dreg_wr) n_dwr++;
    if (ctl_reg_rd)  n_rrd++;
    if (ctl_reg_wr)  n_rwr++;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [15:0] a);
    @(negedge clk); cpu_addr = a; cpu_rd = 1;
    #1; cap_dout = cpu_dout; cap_sa = sram_addr; cap_sel = ctl_reg_sel; cap_we = sram_we;
    @(negedge clk); @(negedge clk); cpu_rd = 0;
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] v);
    @(negedge clk); cpu_addr = a; cpu_din = v; cpu_wr = 1;
    #1; cap_we = sram_we; cap_sa = sram_addr; cap_wd = sram_wdata; cap_sel = ctl_reg_sel; cap_cwd = ctl_wdata;
    @(negedge clk); @(negedge clk); cpu_wr = 0;
  endtask

  task automatic t_reset;
    #1;
    chk(ctl_reset == 1, "R10 ctl_reset", ctl_reset, 1);
    chk(dbg_bank == 0, "R10 banks", dbg_bank, 0);
    @(negedge clk); rst_n = 1;
    rd(16'h4123);
    chk(cap_sa == 17'h00123, "R1 page0 addr", cap_sa, 17'h00123);
    chk(cap_dout == patt(17'h00123), "R1 page0 data", cap_dout, patt(17'h00123));
    wr(16'h4010, 8'h55);
    chk(cap_we == 0, "R3 reset read-only", cap_we, 0);
  endtask

  task automatic t_banks;
    wr(16'h6800, 8'h81);
    wr(16'h6000, 8'h83);
    wr(16'h7000, 8'h9F);
    chk(cap_we == 0, "R2 no sram write in cfg range", cap_we, 0);
    wr(16'h7800, 8'h25);
    chk(dbg_bank == 32'h259F8183, "R2 R11 bank bytes", dbg_bank, 32'h259F8183);
  endtask

  task automatic t_map;
    rd(16'h4005);
    chk(cap_sa == 17'h06005, "R1 win0 page3", cap_sa, 17'h06005);
    rd(16'h8ABC);
    chk(cap_sa == 17'h1EABC, "R1 masked page F", cap_sa, 17'h1EABC);
    rd(16'hA001);
    chk(cap_sa == 17'h0A001, "R1 mirror page5", cap_sa, 17'h0A001);
    chk(cap_dout == patt(17'h0A001), "R1 mirror data", cap_dout, patt(17'h0A001));
    rd(16'h6100);
    chk(cap_sa == 17'h02100 && cap_dout == patt(17'h02100), "R9 cfg-range read", cap_sa, 17'h02100);
  endtask

  task automatic t_protect;
    wr(16'h9234, 8'hA7);
    chk(cap_we == 1 && cap_sa == 17'h1F234, "R3 writable window", cap_sa, 17'h1F234);
    chk(cap_wd == 8'hA7, "R3 write data", cap_wd, 8'hA7);
    wr(16'hA234, 8'h11);
    chk(cap_we == 0, "R3 read-only window", cap_we, 0);
  endtask

  task automatic t_ctl;
    int d0, d1, d2, d3;
    wr(16'h7800, 8'h7F);
    d0 = n_drd; rd(16'hA010);
    chk(cap_dout == 8'h3C, "R4 ctl read data", cap_dout, 8'h3C);
    chk(n_drd == d0 + 1, "R5 R7 dreg read once", n_drd - d0, 1);
    d1 = n_dwr; wr(16'hAFFF, 8'h11);
    chk(n_dwr == d1 + 1 && cap_cwd == 8'h11, "R5 R7 dreg write once", n_dwr - d1, 1);
    chk(cap_we == 0, "R4 no sram write", cap_we, 0);
    d2 = n_rrd; rd(16'hB005);
    chk(n_rrd == d2 + 1 && cap_sel == 4'h5, "R6 reg read sel", cap_sel, 4'h5);
    d3 = n_rwr; wr(16'hBFF3, 8'h22);
    chk(n_rwr == d3 + 1 && cap_sel == 4'h3, "R6 reg write sel", cap_sel, 4'h3);
    chk(n_drd == d0 + 1 && n_dwr == d1 + 1, "R7 no stray strobes", n_drd - d0, 1);
    wr(16'h6000, 8'h40);
    d2 = n_rrd; ctl_rdata = 8'hC7; rd(16'h5800);
    chk(n_rrd == d2 + 1 && cap_sel == 0 && cap_dout == 8'hC7, "R4 alias 0x40", cap_dout, 8'hC7);
    wr(16'h6000, 8'hC0);
    wr(16'h4001, 8'h99);
    chk(cap_we == 1 && cap_sa == 17'h00001, "R4 0xC0 is sram", cap_sa, 17'h00001);
  endtask

  task automatic t_outside;
    int s;
    s = n_drd + n_dwr + n_rrd + n_rwr;
    rd(16'h2000);
    chk(cap_dout == 8'hFF, "R8 low read", cap_dout, 8'hFF);
    rd(16'hC000);
    chk(cap_dout == 8'hFF, "R8 high read", cap_dout, 8'hFF);
    wr(16'hFFFF, 8'h5A);
    chk(cap_we == 0, "R8 no write", cap_we, 0);
    chk(n_drd + n_dwr + n_rrd + n_rwr == s, "R8 no strobes", n_drd + n_dwr + n_rrd + n_rwr - s, 0);
  endtask

  task automatic t_reset_again;
    @(negedge clk); rst_n = 0; #1;
    chk(dbg_bank == 0 && ctl_reset == 1, "R10 re-reset", dbg_bank, 0);
    @(negedge clk); rst_n = 1;
  endtask

  initial begin
    t_reset();
    t_banks();
    t_map();
    t_protect();
    t_ctl();
    t_outside();
    t_reset_again();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule